// File: doc/BRIEF.md
# SPI Burst Register Access Slave

This block is the serial front end of a register-mapped peripheral. A host drives an SPI link in mode 0 (clock idles low, data sampled on the rising edge) with an active-low select. Each select-low period is one frame. The block turns each frame into a burst of 32-bit reads or writes on a simple local register bus. The bus carries an address, write data, a write strobe, a read strobe and read data.

A frame opens with a 32-bit header made of four bytes, in order: opcode, address high byte, address low byte, and a word count. After the header come the data words, most significant byte first. On every frame the block shifts out a global status byte while the opcode arrives, so the host learns of pending faults without an extra access. A small error register, held inside the block at word address 0x000C, records framing faults until the host clears it.

The SPI pins are synchronised into the system clock domain. The host must keep each SCLK phase at least four system clocks long. It must also wait at least six system clocks between select falling and the first rising SCLK edge.

Top module: `spi_burst_slave`

## Requirements
- R1: Opcode 0x61 is a burst write. Each completed 32-bit data word produces one bus_we pulse, with that word (first received bit = bit 31) on bus_wdata. The first word goes to the header address, and each later word goes to the previous address plus 4. bus_we and bus_re are never high together.
- R2: Opcode 0x41 is a burst read. Read data starts right after the header, MSB first. Each word is fetched with one bus_re pulse, and bus_rdata is captured on the clock edge at which bus_re is high. The address steps by 4 per word, as for writes.
- R3: A count byte of 0 means 256 words, which is the largest burst.
- R4: During the first eight bits of every frame, MISO carries a status byte, MSB first. Bit 3 is 1 when any error flag is set, bit 1 equals core_irq, and all other bits are 0.
- R5: An opcode other than 0x41 or 0x61 sets error bit 20. The rest of that frame makes no bus strobe and sets no other flag.
- R6: If select rises after the header but before the announced count of words is complete, bit 18 is set for a write and bit 16 for a read.
- R7: Each data word clocked beyond the announced count sets bit 19 for a write or bit 17 for a read. Such a word makes no bus strobe, and read data for it is all zeros.
- R8: A frame whose total bit count is not a multiple of 32 sets bit 21.
- R9: A read of address 0x000C returns the error register without a bus strobe. The register holds flags in bits 21..16, bit 1 equal to the OR of those flags, and zeros elsewhere.
- R10: A write to address 0x000C clears each flag in bits 21..16 whose data bit is 1, without a bus strobe. Otherwise the flags are sticky.
- R11: After reset, MISO is 0, no strobe is active and the error register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI clock from the host |
| spi_csn | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| core_irq | input | 1 | Pending core interrupt, reported in the status byte |
| bus_addr | output | 16 | Register bus byte address |
| bus_wdata | output | 32 | Register bus write data |
| bus_we | output | 1 | Register bus write strobe, one cycle per word |
| bus_re | output | 1 | Register bus read strobe, one cycle per word |
| bus_rdata | input | 32 | Register bus read data |

## Verification
Random write-then-read bursts of one to six words at random word addresses show that addresses step, bytes are ordered MSB first, and the strobe count per frame is correct. Directed frames then target the framing cases one at a time:
- a short frame, distinguishing underflow for read versus write;
- an overlong frame, distinguishing overflow and the suppressed strobe;
- a ragged bit count, which sets the boundary flag;
- a bad opcode, which sets only the invalid-command flag.

After each fault, the error register is read back through the frame interface. The status byte of that read frame is checked at the same time. A count byte of zero is driven through a full 256-word write to show that the count wraps to 256.

// File: rtl/spi_burst_slave.sv
module spi_burst_slave #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter logic [7:0] OP_RD = 8'h41,
  parameter logic [7:0] OP_WR = 8'h61,
  parameter logic [15:0] ERR_ADDR = 16'h000C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_sclk,
  input  logic          spi_csn,
  input  logic          spi_mosi,
  output logic          spi_miso,
  input  logic          core_irq,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_we,
  output logic          bus_re,
  input  logic [DW-1:0] bus_rdata
);
  localparam int BW = $clog2(DW);
  localparam int CW = 9;

  logic [2:0] sck_q, csn_q;
  logic [1:0] mosi_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q <= '0; csn_q <= '1; mosi_q <= '0;
    end else begin
      sck_q <= {sck_q[1:0], spi_sclk};
      csn_q <= {csn_q[1:0], spi_csn};
      mosi_q <= {mosi_q[0], spi_mosi};
    end

  wire active   = ~csn_q[1];
  wire sck_rise = active & sck_q[1] & ~sck_q[2];
  wire sck_fall = active & ~sck_q[1] & sck_q[2];
  wire cs_start = ~csn_q[1] & csn_q[2];
  wire cs_end   = csn_q[1] & ~csn_q[2];

  logic [DW-1:0] rx_sr, tx_sr, hold;
  logic [BW-1:0] bpos;
  logic          hdr_done, is_rd, ignore, loc_q;
  logic [CW-1:0] cnt, words;
  logic [AW-1:0] waddr;
  logic [5:0]    flags;

  wire [DW-1:0] word_in   = {rx_sr[DW-2:0], mosi_q[1]};
  wire          word_done = sck_rise & (bpos == BW'(DW-1));
  wire [7:0]    op        = word_in[31:24];
  wire          hdr_ok    = (op == OP_RD) | (op == OP_WR);
  wire [CW-1:0] hdr_cnt   = (word_in[7:0] == 8'd0) ? 9'd256 : {1'b0, word_in[7:0]};
  wire          in_range  = words < cnt;
  wire          data_word = word_done & hdr_done & ~ignore;
  wire          take      = data_word & in_range;

  wire          pf_go   = word_done & ~ignore &
                          ((~hdr_done & (op == OP_RD)) |
                           (hdr_done & is_rd & in_range & (({1'b0, words} + 10'd1) < {1'b0, cnt})));
  wire [AW-1:0] pf_addr = hdr_done ? waddr + AW'(4) : word_in[23:8];
  wire          pf_loc  = pf_addr == ERR_ADDR;
  wire          wr_go   = take & ~is_rd;
  wire          wr_loc  = waddr == ERR_ADDR;
  wire          clr_now = wr_go & wr_loc;
  wire [5:0]    clr_msk = clr_now ? word_in[21:16] : 6'd0;

  wire inv_set = word_done & ~hdr_done & ~ignore & ~hdr_ok;
  wire ovf_set = data_word & ~in_range;
  wire end_set = cs_end & ~ignore & (bpos != '0);
  wire unf_set = cs_end & ~ignore & hdr_done & in_range;
  wire [5:0] set_vec = {end_set, inv_set, ovf_set & ~is_rd, unf_set & ~is_rd,
                        ovf_set & is_rd, unf_set & is_rd};

  wire [DW-1:0] err_word = {10'd0, flags, 14'd0, |flags, 1'b0};
  wire [7:0]    status   = {4'd0, |flags, 1'b0, core_irq, 1'b0};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_msk) | set_vec;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_sr <= '0; bpos <= '0; hdr_done <= 1'b0; is_rd <= 1'b0; ignore <= 1'b0;
      cnt <= '0; words <= '0; waddr <= '0;
    end else if (cs_end || cs_start) begin
      bpos <= '0; hdr_done <= 1'b0; ignore <= 1'b0; words <= '0;
    end else if (sck_rise) begin
      rx_sr <= word_in;
      bpos  <= bpos + 1'b1;
      if (word_done && !hdr_done && !ignore) begin
        if (hdr_ok) begin
          hdr_done <= 1'b1;
          is_rd    <= op == OP_RD;
          cnt      <= hdr_cnt;
          waddr    <= word_in[23:8];
        end else ignore <= 1'b1;
      end
      if (take) begin
        words <= words + 1'b1;
        waddr <= waddr + AW'(4);
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bus_we <= 1'b0; bus_re <= 1'b0; loc_q <= 1'b0; bus_addr <= '0; bus_wdata <= '0;
    end else begin
      bus_we <= wr_go & ~wr_loc;
      bus_re <= pf_go & ~pf_loc;
      loc_q  <= pf_go & pf_loc;
      if (pf_go) bus_addr <= pf_addr;
      else if (wr_go && !wr_loc) begin
        bus_addr  <= waddr;
        bus_wdata <= word_in;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hold <= '0;
    else if (bus_re) hold <= bus_rdata;
    else if (loc_q) hold <= err_word;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tx_sr <= '0;
    else if (cs_start) tx_sr <= {status, 24'd0};
    else if (cs_end) tx_sr <= '0;
    else if (sck_fall) begin
      if (bpos == '0 && hdr_done)
        tx_sr <= (is_rd && !ignore && in_range) ? hold : '0;
      else
        tx_sr <= {tx_sr[DW-2:0], 1'b0};
    end

  assign spi_miso = tx_sr[DW-1];

  p_strobe_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_we, bus_re}));
  p_we_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |=> !bus_we);
  p_re_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re |=> !bus_re);
  p_status_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_start |=> (spi_miso == 1'b0) && (tx_sr[27] == $past(|flags)));
  p_end_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_end && !ignore && bpos != '0) |=> flags[5]);
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_now |=> ((flags & $past(flags)) == $past(flags)));
endmodule

// File: tb/sim_spi_burst_slave.sv
module sim_spi_burst_slave;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, csn = 1'b1, mosi = 1'b0, core_irq = 1'b0;
  logic miso, bus_we, bus_re;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  always #4 clk = ~clk;

  spi_burst_slave u0 (.clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_csn(csn), .spi_mosi(mosi),
    .spi_miso(miso), .core_irq(core_irq), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata));

  localparam logic [31:0] F_END = 32'h0020_0000, F_INV = 32'h0010_0000, F_WOVF = 32'h0008_0000,
                          F_WUNF = 32'h0004_0000, F_ROVF = 32'h0002_0000, F_RUNF = 32'h0001_0000,
                          F_SUM = 32'h0000_0002;

  logic [31:0] mem [0:63];
  logic [31:0] exp_mem [0:63];
  logic [31:0] txw [0:299];
  logic [31:0] rxw [0:299];
  logic [7:0]  st_byte;
  int total = 0, bad = 0, we_cnt = 0, re_cnt = 0;
  logic [15:0] last_we_addr;
  logic [31:0] last_we_data;
  logic done = 1'b0;

  function automatic logic [31:0] seed_val(input int i);
    return 32'hA500_0000 ^ (i * 32'h0101_0107);
  endfunction

  assign bus_rdata = mem[bus_addr[7:2]];
  always @(posedge clk) begin
    if (bus_we) begin
      mem[bus_addr[7:2]] <= bus_wdata;
      we_cnt <= we_cnt + 1;
      last_we_addr <= bus_addr;
      last_we_data <= bus_wdata;
    end
    if (bus_re) re_cnt <= re_cnt + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bitx(input logic b, output logic r);
    @(negedge clk); sclk = 1'b0; mosi = b;
    repeat (3) @(negedge clk);
    r = miso;
    @(negedge clk); sclk = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] op, input logic [15:0] a, input logic [7:0] ln,
                       input int nw, input int xb);
    logic [31:0] hdr;
    logic r;
    hdr = {op, a, ln};
    @(negedge clk); we_cnt = 0; re_cnt = 0;
    csn = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 31; i >= 0; i--) begin
      bitx(hdr[i], r);
      if (i >= 24) st_byte[i-24] = r;
    end
    for (int w = 0; w < nw; w++)
      for (int i = 31; i >= 0; i--) begin
        bitx(txw[w][i], r);
        rxw[w][i] = r;
      end
    for (int i = 0; i < xb; i++) bitx(1'b1, r);
    @(negedge clk); sclk = 1'b0;
    repeat (4) @(negedge clk);
    csn = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic read_err(output logic [31:0] v);
    frame(8'h41, 16'h000C, 8'd1, 1, 0);
    v = rxw[0];
  endtask

  task automatic clear_err();
    txw[0] = 32'h003F_0000;
    frame(8'h61, 16'h000C, 8'd1, 1, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n, base;
    void'($urandom(32'd2024));
    for (int i = 0; i < 64; i++) begin mem[i] = seed_val(i); exp_mem[i] = seed_val(i); end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R11 miso after reset", {31'd0, miso}, 32'd0);
    chk("R11 strobes after reset", {30'd0, bus_we, bus_re}, 32'd0);
    read_err(v);
    chk("R11 error register after reset", v, 32'd0);
    chk("R9 local read no strobe", re_cnt, 0);

    for (int k = 0; k < 3; k++) txw[k] = 32'h1122_3344 + k * 32'h0101_0101;
    frame(8'h61, 16'h0100, 8'd3, 3, 0);
    for (int k = 0; k < 3; k++) exp_mem[k] = txw[k];
    chk("R1 write strobe count", we_cnt, 3);
    for (int k = 0; k < 3; k++) chk("R1 write data", mem[k], exp_mem[k]);
    frame(8'h41, 16'h0100, 8'd3, 3, 0);
    chk("R2 read strobe count", re_cnt, 3);
    for (int k = 0; k < 3; k++) chk("R2 read data", rxw[k], exp_mem[k]);
    chk("R4 status clean", {24'd0, st_byte}, 32'h00);
    core_irq = 1'b1;
    frame(8'h41, 16'h0104, 8'd1, 1, 0);
    chk("R4 status irq bit", {24'd0, st_byte}, 32'h02);
    chk("R2 single word", rxw[0], exp_mem[1]);
    core_irq = 1'b0;

    for (int it = 0; it < 6; it++) begin
      n = $urandom_range(1, 6);
      base = 16 + $urandom_range(0, 20);
      for (int k = 0; k < n; k++) begin txw[k] = $urandom; exp_mem[base + k] = txw[k]; end
      frame(8'h61, 16'(base * 4), 8'(n), n, 0);
      chk("R1 random write count", we_cnt, n);
      frame(8'h41, 16'(base * 4), 8'(n), n, 0);
      chk("R2 random read count", re_cnt, n);
      for (int k = 0; k < n; k++) chk("R2 random read data", rxw[k], exp_mem[base + k]);
    end

    txw[0] = 32'hDEAD_BEEF; txw[1] = 32'h0BAD_F00D;
    frame(8'h55, 16'h0100, 8'd2, 2, 0);
    chk("R5 no strobes after bad opcode", we_cnt + re_cnt, 0);
    chk("R5 memory untouched", mem[0], exp_mem[0]);
    read_err(v);
    chk("R5 invalid flag", v, F_INV | F_SUM);
    chk("R4 status error bit", {24'd0, st_byte}, 32'h08);
    clear_err();
    chk("R10 clear no strobe", we_cnt, 0);
    read_err(v);
    chk("R10 flags cleared", v, 32'd0);

    txw[0] = 32'h0000_0001; txw[1] = 32'h0000_0002;
    frame(8'h61, 16'h0140, 8'd4, 2, 0);
    exp_mem[16] = txw[0]; exp_mem[17] = txw[1];
    chk("R6 partial write count", we_cnt, 2);
    read_err(v);
    chk("R6 write underflow", v, F_WUNF | F_SUM);
    clear_err();
    frame(8'h41, 16'h0140, 8'd3, 1, 0);
    chk("R6 partial read data", rxw[0], exp_mem[16]);
    read_err(v);
    chk("R6 read underflow", v, F_RUNF | F_SUM);
    clear_err();

    txw[0] = 32'hAAAA_0001; txw[1] = 32'hAAAA_0002; txw[2] = 32'hAAAA_0003;
    frame(8'h61, 16'h0080, 8'd2, 3, 0);
    exp_mem[32] = txw[0]; exp_mem[33] = txw[1];
    chk("R7 write overflow strobe count", we_cnt, 2);
    chk("R7 extra word ignored", mem[34], exp_mem[34]);
    read_err(v);
    chk("R7 write overflow flag", v, F_WOVF | F_SUM);
    clear_err();
    frame(8'h41, 16'h0080, 8'd1, 2, 0);
    chk("R7 read overflow strobe count", re_cnt, 1);
    chk("R7 read first word", rxw[0], exp_mem[32]);
    chk("R7 read extra word zero", rxw[1], 32'd0);
    read_err(v);
    chk("R7 read overflow flag", v, F_ROVF | F_SUM);
    clear_err();

    txw[0] = 32'h5555_AAAA;
    frame(8'h61, 16'h0084, 8'd1, 1, 5);
    exp_mem[33] = txw[0];
    chk("R8 word still written", we_cnt, 1);
    read_err(v);
    chk("R8 end error flag", v, F_END | F_SUM);
    clear_err();
    read_err(v);
    chk("R10 end flag cleared", v, 32'd0);

    for (int k = 0; k < 256; k++) txw[k] = k;
    frame(8'h61, 16'h0400, 8'd0, 256, 0);
    for (int k = 0; k < 64; k++) exp_mem[k] = 192 + k;
    chk("R3 zero count means 256 words", we_cnt, 256);
    chk("R3 last address", {16'd0, last_we_addr}, 32'h07FC);
    chk("R3 last data", last_we_data, 32'd255);
    read_err(v);
    chk("R3 no fault on full burst", v, 32'd0);
    chk("R3 memory image", mem[5], exp_mem[5]);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule